// File: doc/BRIEF.md
# One-Hot Residue Adder/Subtractor

This block adds or subtracts small residues that are carried in one-hot form. It has three channels working side by side in the same cycle, with moduli 5, 7 and 8 (the set 2^(n-1)+1, 2^n-1, 2^n for n = 3). Each channel receives a data operand and a shift operand, both one-hot. One shared mode input selects addition or subtraction for all three channels. Each channel returns the one-hot sum or difference modulo its own modulus. No carry or borrow passes between channels.

Each result is a rotation of the data vector. The shift operand picks the rotation through a one-hot-selected OR of AND terms, so no binary carry chain exists anywhere in the datapath. Each channel also checks that both of its operands have exactly one active wire. It raises an error flag when an operand is the zero vector or has more than one wire high; the result is then undefined. By default the result and the flag are registered once at the output. The registered output resets to the code for residue 0 with the flag low.

A residue modulo m travels on a vector declared `[0:m-1]`. Residue v is carried by element v alone, so the leftmost element stands for 0 and the rightmost for m-1.

Top module: `ohr_addsub`

## Requirements
- R1: A residue v modulo m is encoded on a vector declared [0:m-1] with only element v high; value 0 is the leftmost element (for m = 5, 0 is 5'b10000 and 1 is 5'b01000).
- R2: With sub_sel = 0, each channel returns the one-hot code of (data + shift) mod m, with m = 5 on channel 0, 7 on channel 1 and 8 on channel 2.
- R3: With sub_sel = 1, each channel returns the one-hot code of (data - shift) mod m, wrapping below zero (for example 1 - 3 mod 5 = 3).
- R4: Whenever both operands of a channel are valid one-hot codes, its result has exactly one wire high.
- R5: A channel's error flag is 1 exactly when its data or shift operand has zero wires or more than one wire high, and 0 when both have exactly one.
- R6: The channels are independent: an invalid operand or any operand value on one channel does not change the result or error flag of another channel.
- R7: With the default REG_OUT = 1, result and error flag change only at a rising clock edge and reflect the operands present at that edge.
- R8: While rst_n is low (asynchronous, active low), every result holds the code for residue 0 and every error flag is 0.
- R9: Adding a shift of 0 returns the data operand unchanged, and subtracting a value from itself returns the code for 0, on every channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_sel | input | 1 | 0 = add, 1 = subtract, shared by all channels |
| d0 | input | 5 | Channel 0 data operand, one-hot modulo 5 |
| s0 | input | 5 | Channel 0 shift operand, one-hot modulo 5 |
| d1 | input | 7 | Channel 1 data operand, one-hot modulo 7 |
| s1 | input | 7 | Channel 1 shift operand, one-hot modulo 7 |
| d2 | input | 8 | Channel 2 data operand, one-hot modulo 8 |
| s2 | input | 8 | Channel 2 shift operand, one-hot modulo 8 |
| q0 | output | 5 | Channel 0 one-hot result |
| q1 | output | 7 | Channel 1 one-hot result |
| q2 | output | 8 | Channel 2 one-hot result |
| err0 | output | 1 | Channel 0 invalid-operand flag |
| err1 | output | 1 | Channel 1 invalid-operand flag |
| err2 | output | 1 | Channel 2 invalid-operand flag |

## Verification
The assertions check the following on every cycle of every channel:
- a valid result is always one-hot;
- the error flag follows the operands' validity one edge later;
- a zero shift in add mode passes the data through;
- subtracting a value from itself gives the zero code.

The exact modular values, the wrap in subtraction, the fixed wire position of each residue, the isolation between channels and the reset state can only be shown by the bench's scenarios. The bench shows them by running every operand pair of every modulus in both modes against integer arithmetic, plus directed invalid-operand and reset cases.

// File: rtl/ohr_pkg.sv
package ohr_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    localparam int NUM_CH = 3;

endpackage

// File: rtl/ohr_rotator.sv
module ohr_rotator
    import ohr_pkg::*;
#(
    parameter int M = 5
) (
    input  op_e          op,
    input  logic [0:M-1] data,
    input  logic [0:M-1] shift,
    output logic [0:M-1] res
);

    // term matrices: element [j][k] is the contribution of shift wire k to output wire j
    logic [0:M-1] add_t [0:M-1];
    logic [0:M-1] sub_t [0:M-1];

    for (genvar j = 0; j < M; j++) begin : g_out
        for (genvar k = 0; k < M; k++) begin : g_amt
            localparam int ADD_SRC = (j + M - k) % M;
            localparam int SUB_SRC = (j + k) % M;
            assign add_t[j][k] = shift[k] & data[ADD_SRC];
            assign sub_t[j][k] = shift[k] & data[SUB_SRC];
        end
        assign res[j] = (op == OP_SUB) ? (|sub_t[j]) : (|add_t[j]);
    end

    // R4: a rotation of a one-hot vector selected by a one-hot amount stays one-hot
    always_comb begin
        if ($countones(data) == 1 && $countones(shift) == 1) begin
            a_onehot_rot_r4: assert ($countones(res) == 1)
                else $error("rotator output not one-hot");
        end
    end

endmodule

// File: rtl/ohr_validity.sv
module ohr_validity #(
    parameter int M = 5
) (
    input  logic [0:M-1] data,
    input  logic [0:M-1] shift,
    output logic         bad
);

    localparam int CW = $clog2(M + 1);

    logic [CW-1:0] n_data;
    logic [CW-1:0] n_shift;

    always_comb begin
        n_data  = '0;
        n_shift = '0;
        for (int i = 0; i < M; i++) begin
            n_data  = n_data  + CW'(data[i]);
            n_shift = n_shift + CW'(shift[i]);
        end
    end

    assign bad = (n_data != CW'(1)) || (n_shift != CW'(1));

endmodule

// File: rtl/ohr_channel.sv
module ohr_channel
    import ohr_pkg::*;
#(
    parameter int M       = 5,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sub_sel,
    input  logic [0:M-1] data,
    input  logic [0:M-1] shift,
    output logic [0:M-1] res,
    output logic         err
);

    localparam logic [0:M-1] ZERO_CODE = {1'b1, {(M-1){1'b0}}};

    op_e          op;
    logic [0:M-1] res_c;
    logic         err_c;

    assign op = op_e'(sub_sel);

    ohr_rotator #(.M(M)) u_rot (
        .op    (op),
        .data  (data),
        .shift (shift),
        .res   (res_c)
    );

    ohr_validity #(.M(M)) u_val (
        .data  (data),
        .shift (shift),
        .bad   (err_c)
    );

    if (REG_OUT) begin : g_reg
        logic [0:M-1] res_q;
        logic         err_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q <= ZERO_CODE;
                err_q <= 1'b0;
            end else begin
                res_q <= res_c;
                err_q <= err_c;
            end
        end

        assign res = res_q;
        assign err = err_q;

        p_onehot_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !err |-> ($countones(res) == 1));

        p_err_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(data) != 1 || $countones(shift) != 1) |=> err);

        p_no_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(data) == 1 && $countones(shift) == 1) |=> !err);

        p_zero_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!sub_sel && shift == ZERO_CODE && $countones(data) == 1)
            |=> (res == $past(data)));

        p_sub_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sub_sel && data == shift && $countones(data) == 1)
            |=> (res == ZERO_CODE));
    end else begin : g_comb
        assign res = res_c;
        assign err = err_c;
    end

endmodule

// File: rtl/ohr_addsub.sv
module ohr_addsub
    import ohr_pkg::*;
#(
    parameter int M0      = 5,
    parameter int M1      = 7,
    parameter int M2      = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sub_sel,
    input  logic [0:M0-1] d0,
    input  logic [0:M0-1] s0,
    input  logic [0:M1-1] d1,
    input  logic [0:M1-1] s1,
    input  logic [0:M2-1] d2,
    input  logic [0:M2-1] s2,
    output logic [0:M0-1] q0,
    output logic [0:M1-1] q1,
    output logic [0:M2-1] q2,
    output logic          err0,
    output logic          err1,
    output logic          err2
);

    ohr_channel #(.M(M0), .REG_OUT(REG_OUT)) u_ch0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .sub_sel (sub_sel),
        .data    (d0),
        .shift   (s0),
        .res     (q0),
        .err     (err0)
    );

    ohr_channel #(.M(M1), .REG_OUT(REG_OUT)) u_ch1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .sub_sel (sub_sel),
        .data    (d1),
        .shift   (s1),
        .res     (q1),
        .err     (err1)
    );

    ohr_channel #(.M(M2), .REG_OUT(REG_OUT)) u_ch2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .sub_sel (sub_sel),
        .data    (d2),
        .shift   (s2),
        .res     (q2),
        .err     (err2)
    );

endmodule

// File: tb/ohr_addsub_test.sv
module ohr_addsub_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sub_sel;
    logic [0:4] d0, s0, q0;
    logic [0:6] d1, s1, q1;
    logic [0:7] d2, s2, q2;
    logic       err0, err1, err2;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    ohr_addsub uut (
        .clk(clk), .rst_n(rst_n), .sub_sel(sub_sel),
        .d0(d0), .s0(s0), .d1(d1), .s1(s1), .d2(d2), .s2(s2),
        .q0(q0), .q1(q1), .q2(q2),
        .err0(err0), .err1(err1), .err2(err2)
    );

    // table: {sub, d0, s0, d1, s1, d2, s2}, values as integers
    localparam logic [24:0] VEC [0:11] = '{
        {1'b0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
        {1'b0, 4'd2, 4'd0, 4'd5, 4'd0, 4'd7, 4'd0},
        {1'b0, 4'd4, 4'd1, 4'd6, 4'd1, 4'd7, 4'd1},
        {1'b0, 4'd3, 4'd4, 4'd4, 4'd6, 4'd5, 4'd6},
        {1'b0, 4'd4, 4'd4, 4'd6, 4'd6, 4'd7, 4'd7},
        {1'b1, 4'd1, 4'd3, 4'd2, 4'd5, 4'd0, 4'd1},
        {1'b1, 4'd3, 4'd3, 4'd6, 4'd6, 4'd7, 4'd7},
        {1'b1, 4'd0, 4'd4, 4'd0, 4'd6, 4'd0, 4'd7},
        {1'b1, 4'd4, 4'd0, 4'd6, 4'd0, 4'd7, 4'd0},
        {1'b0, 4'd1, 4'd2, 4'd3, 4'd3, 4'd2, 4'd5},
        {1'b1, 4'd2, 4'd4, 4'd1, 4'd4, 4'd3, 4'd6},
        {1'b0, 4'd3, 4'd2, 4'd5, 4'd2, 4'd6, 4'd2}
    };

    function automatic logic [0:4] en5(int v);
        en5 = '0; en5[v] = 1'b1;
    endfunction
    function automatic logic [0:6] en7(int v);
        en7 = '0; en7[v] = 1'b1;
    endfunction
    function automatic logic [0:7] en8(int v);
        en8 = '0; en8[v] = 1'b1;
    endfunction

    function automatic int op_mod(int a, int b, logic sub, int m);
        op_mod = sub ? ((a - b + m) % m) : ((a + b) % m);
    endfunction

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic drive(logic sub, int a0, int b0, int a1, int b1, int a2, int b2);
        sub_sel = sub;
        d0 = en5(a0); s0 = en5(b0);
        d1 = en7(a1); s1 = en7(b1);
        d2 = en8(a2); s2 = en8(b2);
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 100000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 3, 1, 4, 2, 5, 6);
        repeat (3) @(posedge clk);
        #2;
        // R8: reset holds zero code and clear flags
        chk("R8", "q0 in reset", 8'(q0), 8'(en5(0)));
        chk("R8", "q1 in reset", 8'(q1), 8'(en7(0)));
        chk("R8", "q2 in reset", 8'(q2), 8'(en8(0)));
        chk("R8", "errs in reset", 8'({err0, err1, err2}), 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: literal encodings, 0 + 1 = 1 on modulus 5
        @(negedge clk);
        sub_sel = 1'b0; d0 = 5'b10000; s0 = 5'b01000;
        step();
        chk("R1", "0+1 literal mod5", 8'(q0), 8'(5'b01000));

        // table walk: R2, R3, R9
        foreach (VEC[i]) begin
            logic [24:0] v;
            int a0, b0, a1, b1, a2, b2;
            v = VEC[i];
            a0 = int'(v[23:20]); b0 = int'(v[19:16]);
            a1 = int'(v[15:12]); b1 = int'(v[11:8]);
            a2 = int'(v[7:4]);   b2 = int'(v[3:0]);
            @(negedge clk);
            drive(v[24], a0, b0, a1, b1, a2, b2);
            step();
            chk(v[24] ? "R3" : "R2", "table ch0", 8'(q0), 8'(en5(op_mod(a0, b0, v[24], 5))));
            chk(v[24] ? "R3" : "R2", "table ch1", 8'(q1), 8'(en7(op_mod(a1, b1, v[24], 7))));
            chk(v[24] ? "R3" : "R2", "table ch2", 8'(q2), 8'(en8(op_mod(a2, b2, v[24], 8))));
        end

        // exhaustive pairs in both modes: R2, R3, R4, R5, R9
        for (int sb = 0; sb < 2; sb++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    @(negedge clk);
                    drive(sb[0], a % 5, b % 5, a % 7, b % 7, a, b);
                    step();
                    if (a < 5 && b < 5)
                        chk(sb[0] ? "R3" : "R2", "mod5 pair", 8'(q0),
                            8'(en5(op_mod(a, b, sb[0], 5))));
                    if (a < 7 && b < 7)
                        chk(sb[0] ? "R3" : "R2", "mod7 pair", 8'(q1),
                            8'(en7(op_mod(a, b, sb[0], 7))));
                    chk(sb[0] ? "R3" : "R2", "mod8 pair", 8'(q2),
                        8'(en8(op_mod(a, b, sb[0], 8))));
                    chk("R4", "mod8 one wire", 8'($countones(q2)), 8'd1);
                    chk("R5", "valid no error", 8'({err0, err1, err2}), 8'd0);
                    if (b == 0 && sb == 0)
                        chk("R9", "zero shift mod8", 8'(q2), 8'(en8(a)));
                    if (a == b && sb == 1)
                        chk("R9", "self sub mod8", 8'(q2), 8'(en8(0)));
                end
            end
        end

        // R5 and R6: invalid operands, one channel at a time
        @(negedge clk);
        drive(1'b0, 2, 2, 3, 1, 4, 4);
        d0 = 5'b00000;
        step();
        chk("R5", "zero data err0", 8'(err0), 8'd1);
        chk("R6", "ch1 unaffected", 8'({err1, q1}), 8'({1'b0, en7(4)}));
        chk("R6", "ch2 unaffected", 8'(q2), 8'(en8(0)));
        chk("R6", "err2 low", 8'(err2), 8'd0);

        @(negedge clk);
        drive(1'b1, 4, 1, 5, 2, 6, 1);
        s1 = 7'b0110000;
        step();
        chk("R5", "multi-hot shift err1", 8'(err1), 8'd1);
        chk("R6", "ch0 unaffected", 8'({err0, q0}), 8'({1'b0, en5(3)}));
        chk("R6", "ch2 unaffected sub", 8'({err2, q2}), 8'({1'b0, en8(5)}));

        @(negedge clk);
        drive(1'b0, 1, 1, 1, 1, 1, 1);
        d2 = 8'hFF; s2 = 8'h00;
        step();
        chk("R5", "all-ones data err2", 8'(err2), 8'd1);
        chk("R6", "ch0 with ch2 bad", 8'(q0), 8'(en5(2)));

        // R7: new operands do not show before the edge
        @(negedge clk);
        drive(1'b0, 1, 1, 1, 1, 1, 1);
        step();
        @(negedge clk);
        drive(1'b0, 4, 3, 6, 5, 7, 6);
        #1;
        chk("R7", "hold before edge", 8'(q1), 8'(en7(2)));
        chk("R7", "flag hold before edge", 8'(err2), 8'd0);
        step();
        chk("R7", "update after edge", 8'(q1), 8'(en7(4)));
        chk("R7", "update after edge ch2", 8'(q2), 8'(en8(5)));

        // R8: asynchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R8", "async reset q1", 8'(q1), 8'(en7(0)));
        chk("R8", "async reset q2", 8'(q2), 8'(en8(0)));
        @(negedge clk);
        rst_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule